// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that counts edges of its own free-running oscillator, which keeps toggling while the system clock domain idles in sleep. The oscillator arrives as an asynchronous square wave. It is synchronised into the system clock domain, and each rising edge becomes a one-cycle tick. A base counter of `WDT_BITS` bits overflows once every 2^WDT_BITS ticks. An eight-stage prescaler is shared with a general-purpose timer. The assignment input `pre_to_wdt` places the prescaler either after the watchdog overflow (1) or in front of the general timer input (0). `ratio_sel` picks one of eight taps.

A time-out seen while the block is awake raises a one-cycle reset request. A time-out seen while asleep raises a one-cycle wake-up request instead. Software keeps the watchdog quiet by pulsing `clr_wdt`. The sleep-entry strobe also restarts the watchdog. When the configuration bit `cfg_en` is 0, no time-out of either kind can occur. The status output `no_timeout` reads 0 after a time-out and is set back to 1 by reset or by `clr_wdt`.

The controller is a three-state machine:
- `WD_OFF` means disabled.
- `WD_AWAKE` means enabled with sleep low.
- `WD_ASLEEP` means enabled with sleep high.

Its transitions are:
- enable: `WD_OFF` to `WD_AWAKE` or `WD_ASLEEP`, chosen by `sleep_mode`.
- doze: `WD_AWAKE` to `WD_ASLEEP`, when `sleep_mode` rises.
- rouse: `WD_ASLEEP` to `WD_AWAKE`, when `sleep_mode` falls.
- disable: any state to `WD_OFF`, when `cfg_en` is 0.

Each time-out is classified by the registered state in the cycle it occurs.

Top module: `sentinel_wdt`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rst_req` and `wake_req` are 0 and `no_timeout` is 1.
- R2: With `pre_to_wdt`=0, enabled and awake, `rst_req` pulses within 4 clock cycles after the 2^WDT_BITS-th rising edge of `rc_osc` that follows a clear strobe; `ratio_sel` has no effect on this period.
- R3: With `pre_to_wdt`=1, the watchdog period is 2^WDT_BITS * 2^`ratio_sel` oscillator edges, counted from a clear strobe. Select value 7 gives 1:128.
- R4: A `clr_wdt` pulse restarts the base counter. With `pre_to_wdt`=1 it also restarts the prescaler count, so the next time-out comes one full period after the pulse.
- R5: A `sleep_entry` pulse restarts the watchdog in the same way as R4 but leaves `no_timeout` unchanged.
- R6: A time-out in state `WD_ASLEEP` pulses `wake_req` and never `rst_req`.
- R7: `rst_req` and `wake_req` are each one cycle wide and are never high together.
- R8: While `cfg_en`=0, no request is raised and the base counter is held at zero, so counting restarts from zero when the watchdog is re-enabled.
- R9: `no_timeout` falls to 0 on a time-out, rises to 1 on `clr_wdt`, and holds otherwise.
- R10: With `pre_to_wdt`=0, `tmr_out` pulses once per 2^(`ratio_sel`+1) `tmr_src` pulses, counted from a cleared prescaler. Select 0 gives 1:2 and select 7 gives 1:256.
- R11: With `pre_to_wdt`=1, `tmr_out` equals `tmr_src` in the same cycle.
- R12: With `pre_to_wdt`=0, clear and sleep-entry strobes leave the prescaler count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_osc | input | 1 | Free-running watchdog oscillator, asynchronous |
| tmr_src | input | 1 | General timer count pulse |
| tmr_out | output | 1 | General timer pulse after the prescaler (or bypass) |
| clr_wdt | input | 1 | Watchdog clear strobe |
| sleep_entry | input | 1 | Sleep-entry strobe, also restarts the watchdog |
| sleep_mode | input | 1 | High while the device sleeps |
| cfg_en | input | 1 | Configuration enable; 0 disables the watchdog |
| pre_to_wdt | input | 1 | Prescaler assignment: 1 watchdog, 0 general timer |
| ratio_sel | input | $clog2(PRE_STAGES) | Prescaler tap select |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| no_timeout | output | 1 | Status flag, 0 after a watchdog time-out |

## Verification
The bench counts oscillator edges from each strobe and checks the exact edge index of the request. A counter that wrapped one edge early or late, or a prescaler tap off by one, would move that index. It attacks the 1:128 and 1:256 extremes, a clear in the middle of a period, and an enable held low while edges keep coming. A design that let a disabled counter drift would time out early after re-enable. A clear with the prescaler on the general timer must not disturb that timer's count; a design that wiped it would lose a divided pulse. In sleep, a request on the reset line instead of the wake-up line is flagged. So is a sleep-entry strobe that wrongly sets the status flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_AWAKE  = 2'd1,
        WD_ASLEEP = 2'd2
    } wd_state_e;

    // Low-bit mask for a tap of 'bits' stages; zero stages passes every pulse.
    function automatic int unsigned tap_mask(input int unsigned bits);
        return (bits == 0) ? 0 : ((32'd1 << bits) - 32'd1);
    endfunction

endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_osc,
    output logic tick
);
    logic [STAGES-1:0] sh;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            last <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], rc_osc};
            last <= sh[STAGES-1];
        end
    end

    assign tick = sh[STAGES-1] & ~last;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int STAGES = 8,
    localparam int SEL_W = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_to_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             tmr_src,
    input  logic             wdt_ovf,
    input  logic             clr_any,
    output logic             tmr_out,
    output logic             wdt_timeout
);
    import wdt_pkg::*;

    logic [STAGES-1:0] cnt;
    logic [STAGES-1:0] mask;
    logic [SEL_W:0]    nbits;
    logic              in_pulse;
    logic              pclr;
    logic              hit;

    // Watchdog side uses 2^n, general timer side 2^(n+1).
    always_comb begin
        if (pre_to_wdt) nbits = {1'b0, ratio_sel};
        else            nbits = {1'b0, ratio_sel} + 1'b1;
        mask = STAGES'(tap_mask(32'(nbits)));
    end

    assign in_pulse = pre_to_wdt ? wdt_ovf : tmr_src;
    assign pclr     = clr_any & pre_to_wdt;
    assign hit      = in_pulse & ~pclr & ((cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (pclr)     cnt <= '0;
        else if (in_pulse) cnt <= cnt + 1'b1;
    end

    assign tmr_out     = pre_to_wdt ? tmr_src : hit;
    assign wdt_timeout = pre_to_wdt ? hit : wdt_ovf;
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic sleep_mode,
    input  logic clr_wdt,
    input  logic timeout,
    output logic rst_req,
    output logic wake_req,
    output logic no_timeout,
    output logic in_doze
);
    import wdt_pkg::*;

    wd_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_OFF: begin
                if (cfg_en) state_nx = sleep_mode ? WD_ASLEEP : WD_AWAKE;
            end
            WD_AWAKE: begin
                if (!cfg_en)        state_nx = WD_OFF;
                else if (sleep_mode) state_nx = WD_ASLEEP;
            end
            WD_ASLEEP: begin
                if (!cfg_en)         state_nx = WD_OFF;
                else if (!sleep_mode) state_nx = WD_AWAKE;
            end
            default: state_nx = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req    <= 1'b0;
            wake_req   <= 1'b0;
            no_timeout <= 1'b1;
        end else begin
            rst_req  <= timeout && (state == WD_AWAKE);
            wake_req <= timeout && (state == WD_ASLEEP);
            if (clr_wdt)                            no_timeout <= 1'b1;
            else if (timeout && (state != WD_OFF))  no_timeout <= 1'b0;
        end
    end

    assign in_doze = (state == WD_ASLEEP);
endmodule

// File: rtl/sentinel_wdt.sv
module sentinel_wdt #(
    parameter int WDT_BITS    = 8,
    parameter int PRE_STAGES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rc_osc,
    input  logic                          tmr_src,
    output logic                          tmr_out,
    input  logic                          clr_wdt,
    input  logic                          sleep_entry,
    input  logic                          sleep_mode,
    input  logic                          cfg_en,
    input  logic                          pre_to_wdt,
    input  logic [$clog2(PRE_STAGES)-1:0] ratio_sel,
    output logic                          rst_req,
    output logic                          wake_req,
    output logic                          no_timeout
);
    localparam logic [WDT_BITS-1:0] BASE_TOP = '1;

    logic                tick;
    logic [WDT_BITS-1:0] base_cnt;
    logic                clr_any;
    logic                base_hold;
    logic                base_ovf;
    logic                wd_to;
    logic                doze_st;

    wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rc_osc (rc_osc),
        .tick   (tick)
    );

    assign clr_any   = clr_wdt | sleep_entry;
    assign base_hold = clr_any | ~cfg_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         base_cnt <= '0;
        else if (base_hold) base_cnt <= '0;
        else if (tick)      base_cnt <= base_cnt + 1'b1;
    end

    assign base_ovf = tick & ~base_hold & (base_cnt == BASE_TOP);

    wdt_prescaler #(.STAGES(PRE_STAGES)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_to_wdt  (pre_to_wdt),
        .ratio_sel   (ratio_sel),
        .tmr_src     (tmr_src),
        .wdt_ovf     (base_ovf),
        .clr_any     (clr_any),
        .tmr_out     (tmr_out),
        .wdt_timeout (wd_to)
    );

    wdt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .sleep_mode (sleep_mode),
        .clr_wdt    (clr_wdt),
        .timeout    (wd_to),
        .rst_req    (rst_req),
        .wake_req   (wake_req),
        .no_timeout (no_timeout),
        .in_doze    (doze_st)
    );
endmodule

// File: rtl/sentinel_wdt_chk.sv
module sentinel_wdt_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic clr_wdt,
    input logic rst_req,
    input logic wake_req,
    input logic no_timeout,
    input logic in_doze
);
    // R7
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R7
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> (!rst_req && !wake_req));

    // R6
    wake_in_doze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(in_doze));

    // R6
    rst_not_doze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(in_doze));

    // R9
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_timeout) |-> (rst_req || wake_req));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_timeout) |-> $past(clr_wdt));
endmodule

bind sentinel_wdt sentinel_wdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .clr_wdt    (clr_wdt),
    .rst_req    (rst_req),
    .wake_req   (wake_req),
    .no_timeout (no_timeout),
    .in_doze    (doze_st)
);

// File: tb/tb_sentinel_wdt.sv
`timescale 1ns/1ps
module tb_sentinel_wdt;
    localparam int WB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rc_osc = 1'b0, tmr_src = 1'b0, clr_wdt = 1'b0, sleep_entry = 1'b0;
    logic sleep_mode = 1'b0, cfg_en = 1'b1, pre_to_wdt = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic tmr_out, rst_req, wake_req, no_timeout;

    always #2.5 clk = ~clk;

    sentinel_wdt #(.WDT_BITS(WB)) dut (
        .clk(clk), .rst_n(rst_n), .rc_osc(rc_osc), .tmr_src(tmr_src),
        .tmr_out(tmr_out), .clr_wdt(clr_wdt), .sleep_entry(sleep_entry),
        .sleep_mode(sleep_mode), .cfg_en(cfg_en), .pre_to_wdt(pre_to_wdt),
        .ratio_sel(ratio_sel), .rst_req(rst_req), .wake_req(wake_req),
        .no_timeout(no_timeout)
    );

    int n_chk = 0, n_fail = 0;
    int tick_idx, rst_at, wake_at, rst_cnt, wake_cnt, tout_cnt;

    function automatic int exp_ticks(input bit to_wdt, input int sel);
        return (1 << WB) << (to_wdt ? sel : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        if (rst_req)  begin rst_cnt++;  if (rst_at < 0)  rst_at = tick_idx;  end
        if (wake_req) begin wake_cnt++; if (wake_at < 0) wake_at = tick_idx; end
    endtask

    task automatic meas_reset();
        tick_idx = 0; rst_at = -1; wake_at = -1; rst_cnt = 0; wake_cnt = 0;
    endtask

    task automatic rc_period();
        rc_osc = 1'b1; tick_idx++;
        repeat (4) cyc();
        rc_osc = 1'b0;
        repeat (4) cyc();
    endtask

    task automatic strobe_clr();
        clr_wdt = 1'b1; cyc(); clr_wdt = 1'b0; cyc();
    endtask

    task automatic strobe_sleep();
        sleep_entry = 1'b1; cyc(); sleep_entry = 1'b0; cyc();
    endtask

    task automatic tpulse();
        tmr_src = 1'b1; #1;
        if (tmr_out) tout_cnt++;
        cyc(); tmr_src = 1'b0; cyc();
    endtask

    task automatic zero_pre();
        pre_to_wdt = 1'b1; cyc(); strobe_clr();
    endtask

    // Watchdog period measured from a strobe; sleep selects the expected request line.
    task automatic measure(input bit to_wdt, input int sel, input bit slp,
                           input bit via_sleep, input string req);
        int k;
        pre_to_wdt = to_wdt; ratio_sel = 3'(sel); sleep_mode = slp;
        repeat (3) cyc();
        if (via_sleep) strobe_sleep(); else strobe_clr();
        meas_reset();
        k = exp_ticks(to_wdt, sel);
        repeat (k + 3) rc_period();
        if (slp) begin
            chk(wake_at == k, req, wake_at, k);
            chk(rst_cnt == 0, {req, " R6 no reset in sleep"}, rst_cnt, 0);
        end else begin
            chk(rst_at == k, req, rst_at, k);
            chk(rst_cnt == 1, {req, " R7 one pulse"}, rst_cnt, 1);
        end
    endtask

    task automatic run_all();
        meas_reset();
        repeat (5) cyc();
        chk(rst_req == 0 && wake_req == 0, "R1 requests in reset", int'(rst_req), 0);
        rst_n = 1'b1; cyc();
        chk(no_timeout == 1, "R1 flag after reset", int'(no_timeout), 1);
        chk(rst_req == 0 && wake_req == 0, "R1 requests after reset", int'(wake_req), 0);

        // R2: watchdog unprescaled, select ignored
        measure(1'b0, 5, 1'b0, 1'b0, "R2 period sel ignored");
        chk(no_timeout == 0, "R9 flag cleared by time-out", int'(no_timeout), 0);
        strobe_clr();
        chk(no_timeout == 1, "R9 flag set by clear", int'(no_timeout), 1);

        // R3: prescaled periods including 1:128 and 1:1
        measure(1'b1, 3, 1'b0, 1'b0, "R3 ratio 1:8");
        measure(1'b1, 7, 1'b0, 1'b0, "R3 ratio 1:128");
        measure(1'b1, 0, 1'b0, 1'b0, "R3 ratio 1:1");

        // R4: clear in the middle of a period restarts it
        pre_to_wdt = 1'b1; ratio_sel = 3'd1;
        strobe_clr(); meas_reset();
        repeat (20) rc_period();
        chk(rst_cnt == 0, "R4 no time-out before clear", rst_cnt, 0);
        strobe_clr(); meas_reset();
        repeat (35) rc_period();
        chk(rst_at == 32, "R4 period restarts at clear", rst_at, 32);

        // R6 and R5: sleep time-out via sleep-entry strobe
        measure(1'b0, 0, 1'b1, 1'b1, "R5 R6 wake after sleep entry");
        chk(no_timeout == 0, "R9 flag cleared by sleep time-out", int'(no_timeout), 0);
        strobe_sleep();
        chk(no_timeout == 0, "R5 sleep entry leaves flag", int'(no_timeout), 0);
        sleep_mode = 1'b0;

        // R8: disabled watchdog stays quiet and restarts from zero
        pre_to_wdt = 1'b0; strobe_clr(); meas_reset();
        repeat (5) rc_period();
        cfg_en = 1'b0; cyc(); meas_reset();
        repeat (40) rc_period();
        chk(rst_cnt + wake_cnt == 0, "R8 no request while disabled", rst_cnt + wake_cnt, 0);
        cfg_en = 1'b1; cyc(); meas_reset();
        repeat (19) rc_period();
        chk(rst_at == 16, "R8 restart from zero", rst_at, 16);

        // R11: bypass when the prescaler belongs to the watchdog
        pre_to_wdt = 1'b1; tout_cnt = 0;
        repeat (10) tpulse();
        chk(tout_cnt == 10, "R11 bypass", tout_cnt, 10);

        // R10: divider extremes
        zero_pre(); pre_to_wdt = 1'b0; ratio_sel = 3'd0; tout_cnt = 0;
        repeat (7) tpulse();
        chk(tout_cnt == 3, "R10 ratio 1:2", tout_cnt, 3);
        zero_pre(); pre_to_wdt = 1'b0; ratio_sel = 3'd7; tout_cnt = 0;
        repeat (255) tpulse();
        chk(tout_cnt == 0, "R10 ratio 1:256 edge-1", tout_cnt, 0);
        tpulse();
        chk(tout_cnt == 1, "R10 ratio 1:256 edge", tout_cnt, 1);

        // R12: clears do not touch a prescaler assigned to the general timer
        zero_pre(); pre_to_wdt = 1'b0; ratio_sel = 3'd2; tout_cnt = 0;
        repeat (5) tpulse();
        strobe_clr(); strobe_sleep();
        repeat (3) tpulse();
        chk(tout_cnt == 1, "R12 count kept across clear", tout_cnt, 1);

        // Random mix
        void'($urandom(32'd20251));
        for (int i = 0; i < 6; i++) begin
            bit to_wdt = 1'($urandom_range(0, 1));
            int sel    = int'($urandom_range(0, 3));
            bit slp    = 1'($urandom_range(0, 1));
            measure(to_wdt, sel, slp, slp, "R2 R3 R6 random period");
            sleep_mode = 1'b0; cyc();
        end
        for (int i = 0; i < 6; i++) begin
            int sel = int'($urandom_range(0, 3));
            int n   = int'($urandom_range(1, 60));
            int e   = n >> (sel + 1);
            zero_pre(); pre_to_wdt = 1'b0; ratio_sel = 3'(sel); tout_cnt = 0;
            repeat (n) tpulse();
            chk(tout_cnt == e, "R10 random divide", tout_cnt, e);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule